// File: doc/BRIEF.md
# Fault Record Logger

The logger keeps a short, append-only history of fault events in a fixed window of nonvolatile memory. When the surrounding sequencer pulses `trig`, the block takes a snapshot of the state number that was just left, the reason for leaving it, and five 8-bit status words: undervoltage, overvoltage, digital inputs, limit and warning. It packs the snapshot into an 8-byte record, adds a checksum byte, and programs the record one byte at a time into the next free slot of the log window.

Each slot's first byte carries a written flag in bit 7. The flag reads 1 when the slot is erased and is programmed to 0 with the record. After reset, or when `rescan` is pulsed, the block reads the first byte of each slot in ascending order. The first slot whose flag reads 1 becomes the write slot. Once every slot is used, the block raises `full` and ignores further triggers, so the oldest faults survive. The block never erases memory. To reuse the log, an external agent erases the window and then pulses `rescan`.

Both memory channels use valid/ready. The block raises `mem_rd_valid` or `mem_wr_valid` and holds `mem_addr` (and `mem_wr_data`) steady until the memory returns ready. A transfer happens on the rising edge where valid and ready are both high. The memory may hold ready low for any number of cycles, and this back-pressure is how a long byte-programming time is absorbed. Read data is taken in the handshake cycle.

Top module: `fault_record_logger`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `busy` is 1, `full` and `overrun` are 0, `mem_wr_valid` is 0, and a read of the first byte of slot 0 (address `BASE_ADDR`) is requested.
- R2: A search reads address `BASE_ADDR + 8*k` for k = 0, 1, 2, … in ascending order. It stops at the first slot whose byte has bit 7 equal to 1, and that slot receives the next record. Later slots are not read.
- R3: If no slot has bit 7 set, the search ends with `full` = 1. While `full` is 1 a trigger produces no memory write.
- R4: Record layout:
  - byte 0 = {1'b0, cause[1:0], 5'b0}, where cause 1 = sequence, 2 = timeout, 3 = monitor;
  - byte 1 = {2'b0, previous state[5:0]};
  - bytes 2 to 6 = undervoltage, overvoltage, digital-input, limit and warning status, in that order.
- R5: Byte 7 is the two's-complement checksum, so the eight bytes of a record sum to 0 modulo 256.
- R6: A record is written as exactly eight transfers, to addresses `BASE_ADDR + 8*slot + b` for b = 0 to 7 in order. While `mem_wr_valid` is high and `mem_wr_ready` is low, address and data do not change.
- R7: After a record is written to slot k, the next record goes to slot k+1. Completing slot `NUM_SLOTS-1` sets `full`, and the earlier records are never rewritten.
- R8: A trigger in a cycle where the block is busy, or where it starts a search, is dropped and sets the sticky `overrun` flag, which only reset clears. A trigger that is refused only because `full` is 1 leaves `overrun` unchanged.
- R9: A `rescan` pulse starts a new search from slot 0, and that search updates `full`. A pulse that arrives while a record is being written or a search is running is held, and its search starts as soon as the current operation completes.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_addr` does not change.
- R11: `busy` is 1 exactly while a search or a record write is in progress. At most one of `mem_rd_valid` and `mem_wr_valid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | One-cycle request to log a fault snapshot |
| exit_cause | input | 2 | Reason the state was left (1 sequence, 2 timeout, 3 monitor) |
| prev_state | input | 6 | Number of the state that was left |
| uv_status | input | 8 | Undervoltage comparator status |
| ov_status | input | 8 | Overvoltage comparator status |
| din_status | input | 8 | Digital input status |
| lim_status | input | 8 | Limit status |
| warn_status | input | 8 | Warning detector status |
| rescan | input | 1 | Pulse to restart the free-slot search |
| mem_addr | output | ADDR_W | Byte address for the current read or write |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read; `mem_rd_data` is valid |
| mem_rd_data | input | 8 | Byte returned by the memory |
| mem_wr_valid | output | 1 | Byte-program request valid |
| mem_wr_ready | input | 1 | Memory has finished programming the byte |
| mem_wr_data | output | 8 | Byte to program |
| busy | output | 1 | Search or record write in progress |
| full | output | 1 | Every slot is used |
| overrun | output | 1 | Sticky: a trigger was dropped because the block was busy |

## Verification
The bench builds the block with `NUM_SLOTS` = 4 at the default base address. This makes filling the log, hitting the full condition, and erasing and reusing the log quick to reach. It also lets the bench sweep every possible number of used leading slots from zero to four, including a used slot placed after the first free one. The memory model programs bytes by AND-ing them in and varies its ready latency between zero and two cycles. Every record is compared against layout and checksum values the bench computes for itself.

// File: rtl/flog_pkg.sv
package flog_pkg;
  localparam int BYTE_W    = 8;
  localparam int REC_BYTES = 8;
  localparam int BSEL_W    = $clog2(REC_BYTES);
  localparam int STATE_W   = 6;
  localparam int N_STAT    = 5;
  localparam int FLAG_BIT  = 7;

  typedef enum logic [1:0] {
    EXIT_NONE    = 2'd0,
    EXIT_SEQ     = 2'd1,
    EXIT_TIMEOUT = 2'd2,
    EXIT_MONITOR = 2'd3
  } exit_cause_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SEARCH = 2'd1,
    PH_WRITE  = 2'd2
  } phase_t;

  typedef logic [REC_BYTES-1:0][BYTE_W-1:0] record_t;

  // Two's-complement of the sum of all bytes except the last one.
  function automatic logic [BYTE_W-1:0] rec_checksum(record_t r);
    logic [BYTE_W-1:0] s;
    s = '0;
    for (int i = 0; i < REC_BYTES - 1; i++) s = s + r[i];
    return BYTE_W'(0) - s;
  endfunction
endpackage

// File: rtl/flog_record.sv
module flog_record
  import flog_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [1:0]                       cause,
  input  logic [STATE_W-1:0]               prev_state,
  input  logic [N_STAT-1:0][BYTE_W-1:0]    status,
  input  logic [BSEL_W-1:0]                byte_sel,
  output logic [BYTE_W-1:0]                byte_out
);
  record_t rec_d, rec_q;

  always_comb begin
    rec_d[0] = {1'b0, cause, 5'b0};
    rec_d[1] = {{(BYTE_W-STATE_W){1'b0}}, prev_state};
    rec_d[REC_BYTES-1] = '0;
  end

  for (genvar g = 0; g < N_STAT; g++) begin : g_stat
    assign rec_d[2+g] = status[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (load) begin
      rec_q                <= rec_d;
      rec_q[REC_BYTES-1]   <= rec_checksum(rec_d);
    end
  end

  assign byte_out = rec_q[byte_sel];
endmodule

// File: rtl/flog_sequencer.sv
module flog_sequencer
  import flog_pkg::*;
#(
  parameter int          NUM_SLOTS = 16,
  parameter int unsigned BASE_ADDR = 32'hF980,
  parameter int          ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              rescan,
  input  logic              rd_flag,
  input  logic              rd_ready,
  input  logic              wr_ready,
  output logic              rd_valid,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              load,
  output logic [BSEL_W-1:0] byte_sel,
  output logic              busy,
  output logic              full,
  output logic              overrun
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  phase_t            phase;
  logic [SLOT_W-1:0] slot;
  logic [BSEL_W-1:0] bsel;
  logic              full_q, ovr_q, pend_q;
  logic              start_search, accept, refuse, rd_hs, wr_hs, last_slot, again;

  always_comb begin
    start_search = (phase == PH_IDLE) && rescan;
    accept       = (phase == PH_IDLE) && !start_search && !full_q && trig;
    refuse       = trig && !((phase == PH_IDLE) && !start_search);
    rd_hs        = (phase == PH_SEARCH) && rd_ready;
    wr_hs        = (phase == PH_WRITE) && wr_ready;
    last_slot    = (slot == LAST_SLOT);
    again        = pend_q || rescan;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_SEARCH;
      slot   <= '0;
      bsel   <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (refuse) ovr_q <= 1'b1;
      if (rescan && phase != PH_IDLE) pend_q <= 1'b1;
      unique case (phase)
        PH_IDLE: begin
          if (start_search) begin
            phase <= PH_SEARCH;
            slot  <= '0;
          end else if (accept) begin
            phase <= PH_WRITE;
          end
        end
        PH_SEARCH: begin
          if (rd_hs) begin
            if (rd_flag || last_slot) begin
              if (again) begin
                slot   <= '0;
                pend_q <= 1'b0;
              end else begin
                full_q <= !rd_flag;
                phase  <= PH_IDLE;
              end
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        PH_WRITE: begin
          if (wr_hs) begin
            bsel <= bsel + 1'b1;
            if (bsel == BSEL_W'(REC_BYTES - 1)) begin
              if (last_slot) full_q <= 1'b1;
              if (again) begin
                phase  <= PH_SEARCH;
                slot   <= '0;
                pend_q <= 1'b0;
              end else begin
                phase <= PH_IDLE;
                if (!last_slot) slot <= slot + 1'b1;
              end
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign rd_valid = (phase == PH_SEARCH);
  assign wr_valid = (phase == PH_WRITE);
  assign addr     = ADDR_W'(BASE_ADDR) + ADDR_W'({slot, bsel});
  assign load     = accept;
  assign byte_sel = bsel;
  assign busy     = (phase != PH_IDLE);
  assign full     = full_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/fault_record_logger.sv
module fault_record_logger
  import flog_pkg::*;
#(
  parameter int          NUM_SLOTS = 16,
  parameter int unsigned BASE_ADDR = 32'hF980,
  parameter int          ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [1:0]        exit_cause,
  input  logic [5:0]        prev_state,
  input  logic [7:0]        uv_status,
  input  logic [7:0]        ov_status,
  input  logic [7:0]        din_status,
  input  logic [7:0]        lim_status,
  input  logic [7:0]        warn_status,
  input  logic              rescan,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [7:0]        mem_wr_data,
  output logic              busy,
  output logic              full,
  output logic              overrun
);
  logic                          load;
  logic [BSEL_W-1:0]             byte_sel;
  logic [N_STAT-1:0][BYTE_W-1:0] status;
  logic                          unused_rd_bits;

  assign status         = {warn_status, lim_status, din_status, ov_status, uv_status};
  assign unused_rd_bits = ^mem_rd_data[FLAG_BIT-1:0];

  flog_sequencer #(
    .NUM_SLOTS(NUM_SLOTS), .BASE_ADDR(BASE_ADDR), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rescan(rescan),
    .rd_flag(mem_rd_data[FLAG_BIT]), .rd_ready(mem_rd_ready),
    .wr_ready(mem_wr_ready), .rd_valid(mem_rd_valid), .wr_valid(mem_wr_valid),
    .addr(mem_addr), .load(load), .byte_sel(byte_sel),
    .busy(busy), .full(full), .overrun(overrun)
  );

  flog_record u_rec (
    .clk(clk), .rst_n(rst_n), .load(load), .cause(exit_cause),
    .prev_state(prev_state), .status(status), .byte_sel(byte_sel),
    .byte_out(mem_wr_data)
  );
endmodule

// File: rtl/fault_record_logger_chk.sv
module fault_record_logger_chk #(
  parameter int          NUM_SLOTS = 16,
  parameter int unsigned BASE_ADDR = 32'hF980,
  parameter int          ADDR_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [7:0]        mem_wr_data,
  input logic              busy,
  input logic              full,
  input logic              overrun
);
  localparam longint unsigned LIMIT = longint'(BASE_ADDR) + longint'(NUM_SLOTS) * 8;

  logic       wr_hs;
  logic [2:0] exp_b;
  logic [7:0] run_sum;

  assign wr_hs = mem_wr_valid && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_b   <= '0;
      run_sum <= '0;
    end else if (wr_hs) begin
      exp_b   <= exp_b + 1'b1;
      run_sum <= (exp_b == 3'd7) ? 8'd0 : run_sum + mem_wr_data;
    end
  end

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_addr) && $stable(mem_wr_data));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_addr));
  // R11
  one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_valid, mem_wr_valid}));
  // R11
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_wr_valid) |-> busy);
  // R3
  full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !mem_wr_valid);
  // R6
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (longint'(mem_addr) >= longint'(BASE_ADDR)) && (longint'(mem_addr) < LIMIT));
  // R6
  byte_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hs |-> mem_addr[2:0] == exp_b);
  // R5
  checksum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hs && exp_b == 3'd7 |-> 8'(run_sum + mem_wr_data) == 8'd0);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hs && exp_b == 3'd0 |-> !mem_wr_data[7]);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind fault_record_logger fault_record_logger_chk #(
  .NUM_SLOTS(NUM_SLOTS), .BASE_ADDR(BASE_ADDR), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_data(mem_wr_data), .busy(busy), .full(full), .overrun(overrun)
);

// File: tb/fault_record_logger_test.sv
module fault_record_logger_test;
  localparam int          NS   = 4;
  localparam int unsigned BASE = 32'hF980;
  localparam int          MB   = NS * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, trig = 1'b0, rescan = 1'b0;
  logic [1:0]  exit_cause = '0;
  logic [5:0]  prev_state = '0;
  logic [7:0]  uv_status = '0, ov_status = '0, din_status = '0, lim_status = '0, warn_status = '0;
  logic [15:0] mem_addr;
  logic        mem_rd_valid, mem_wr_valid, busy, full, overrun;
  logic [7:0]  mem_wr_data;
  logic        rd_rdy = 1'b0, wr_rdy = 1'b0;
  logic [7:0]  rd_dat = '0;

  fault_record_logger #(.NUM_SLOTS(NS), .BASE_ADDR(BASE), .ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .exit_cause(exit_cause),
    .prev_state(prev_state), .uv_status(uv_status), .ov_status(ov_status),
    .din_status(din_status), .lim_status(lim_status), .warn_status(warn_status),
    .rescan(rescan), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(rd_rdy), .mem_rd_data(rd_dat), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(wr_rdy), .mem_wr_data(mem_wr_data), .busy(busy),
    .full(full), .overrun(overrun)
  );

  logic [7:0]  mem [MB];
  logic [15:0] wa [64];
  logic [7:0]  wd [64];
  logic [15:0] ra [64];
  int wn = 0, rn = 0, lat = 0, wcnt = 0, rcnt = 0;
  int pass_n = 0, fail_n = 0;

  // Memory model: programs by AND, ready after lat waiting cycles, acts at negedge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        wr_rdy = 1'b0; rd_rdy = 1'b0; wcnt = lat; rcnt = lat;
      end else begin
        if (wr_rdy) begin
          wr_rdy = 1'b0; wcnt = lat;
        end else if (mem_wr_valid) begin
          if (wcnt == 0) begin
            int i;
            i = int'(mem_addr) - int'(BASE);
            wr_rdy = 1'b1;
            if (i >= 0 && i < MB) mem[i] = mem[i] & mem_wr_data;
            if (wn < 64) begin wa[wn] = mem_addr; wd[wn] = mem_wr_data; end
            wn++;
          end else wcnt--;
        end
        if (rd_rdy) begin
          rd_rdy = 1'b0; rcnt = lat;
        end else if (mem_rd_valid) begin
          if (rcnt == 0) begin
            int i;
            i = int'(mem_addr) - int'(BASE);
            rd_rdy = 1'b1;
            rd_dat = (i >= 0 && i < MB) ? mem[i] : 8'h00;
            if (rn < 64) ra[rn] = mem_addr;
            rn++;
          end else rcnt--;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int seed, input int b);
    logic [7:0] v [8];
    logic [7:0] s;
    v[0] = {1'b0, 2'((seed % 3) + 1), 5'b0};
    v[1] = 8'((seed * 11 + 5) % 64);
    v[2] = 8'(seed * 37 + 1);
    v[3] = 8'(seed * 53 + 9);
    v[4] = 8'(seed * 29 + 200);
    v[5] = 8'(seed * 71);
    v[6] = 8'(seed * 13 + 77);
    s = 8'd0;
    for (int i = 0; i < 7; i++) s = s + v[i];
    v[7] = 8'd0 - s;
    return v[b];
  endfunction

  task automatic fire(input int seed);
    exit_cause  = 2'((seed % 3) + 1);
    prev_state  = 6'((seed * 11 + 5) % 64);
    uv_status   = 8'(seed * 37 + 1);
    ov_status   = 8'(seed * 53 + 9);
    din_status  = 8'(seed * 29 + 200);
    lim_status  = 8'(seed * 71);
    warn_status = 8'(seed * 13 + 77);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic pulse_rescan();
    rescan = 1'b1;
    @(negedge clk);
    rescan = 1'b0;
  endtask

  task automatic idle_wait();
    for (int t = 0; t < 4000 && busy; t++) @(negedge clk);
    chk(!busy, "R11 busy never cleared", int'(busy), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_record(input int seed, input int slot, input int w0);
    for (int b = 0; b < 8; b++) begin
      chk(wa[w0+b] == 16'(BASE + slot * 8 + b), "R6 write address", int'(wa[w0+b]), int'(BASE) + slot * 8 + b);
      chk(wd[w0+b] == exp_byte(seed, b), (b == 7) ? "R5 checksum byte" : "R4 record byte",
          int'(wd[w0+b]), int'(exp_byte(seed, b)));
    end
  endtask

  task automatic erase_all();
    for (int i = 0; i < MB; i++) mem[i] = 8'hFF;
  endtask

  initial begin
    #(4 * 150000);
    fail_n++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  initial begin
    erase_all();
    repeat (3) @(negedge clk);
    // R1: state during reset and in the first cycle after release
    chk(busy && mem_rd_valid && !mem_wr_valid, "R1 reset request", int'(busy), 1);
    rn = 0; wn = 0;
    rst_n = 1'b1;
    chk(!full && !overrun, "R1 flags clear", int'(full) + int'(overrun), 0);
    chk(mem_addr == 16'(BASE), "R1 first read address", int'(mem_addr), int'(BASE));
    idle_wait();
    chk(rn == 1, "R2 single read on empty log", rn, 1);
    chk(!full, "R2 not full on empty log", int'(full), 0);

    // R7: fill every slot in order
    for (int i = 0; i < NS; i++) begin
      lat = i % 3; wn = 0;
      fire(i);
      chk(busy, "R11 busy during write", int'(busy), 1);
      idle_wait();
      chk(wn == 8, "R6 eight transfers", wn, 8);
      check_record(i, i, 0);
      chk(full == (i == NS - 1), "R7 full after last slot", int'(full), int'(i == NS - 1));
    end

    // R3 / R8: trigger on full log
    wn = 0;
    fire(50);
    idle_wait();
    chk(wn == 0, "R3 no write when full", wn, 0);
    chk(!overrun, "R8 full refusal leaves overrun", int'(overrun), 0);
    for (int b = 0; b < 8; b++)
      chk(mem[b] == exp_byte(0, b), "R7 earliest record kept", int'(mem[b]), int'(exp_byte(0, b)));

    // R9: external erase then search restart
    erase_all(); rn = 0;
    pulse_rescan();
    idle_wait();
    chk(!full, "R9 full cleared after rescan", int'(full), 0);
    chk(rn == 1 && ra[0] == 16'(BASE), "R9 search from slot 0", rn, 1);

    // R8: trigger while busy
    lat = 2; wn = 0;
    fire(60);
    @(negedge clk);
    fire(61);
    chk(overrun, "R8 overrun set", int'(overrun), 1);
    idle_wait();
    chk(wn == 8, "R8 dropped trigger wrote nothing", wn, 8);
    check_record(60, 0, 0);

    // R9: rescan during a write is deferred until the write completes
    lat = 1; wn = 0; rn = 0;
    fire(70);
    pulse_rescan();
    idle_wait();
    chk(wn == 8, "R9 write completes", wn, 8);
    check_record(70, 1, 0);
    chk(rn == 3, "R9 deferred search reads", rn, 3);
    for (int k = 0; k < 3; k++)
      chk(ra[k] == 16'(BASE + 8 * k), "R2 ascending reads", int'(ra[k]), int'(BASE) + 8 * k);

    // R2 / R3: sweep number of used leading slots, with a used slot after the free one
    for (int s = 0; s <= NS; s++) begin
      int exp_rn;
      erase_all();
      for (int k = 0; k < s; k++) mem[k * 8] = 8'h1F;
      if (s + 1 < NS) mem[(s + 1) * 8] = 8'h3A;
      lat = s % 2 + 1; rn = 0;
      pulse_rescan();
      idle_wait();
      exp_rn = (s < NS) ? s + 1 : NS;
      chk(rn == exp_rn, "R2 search read count", rn, exp_rn);
      for (int k = 0; k < exp_rn && k < 64; k++)
        chk(ra[k] == 16'(BASE + 8 * k), "R2 search order", int'(ra[k]), int'(BASE) + 8 * k);
      chk(full == (s == NS), "R3 full from search", int'(full), int'(s == NS));
      wn = 0;
      fire(100 + s);
      idle_wait();
      if (s < NS) begin
        chk(wn == 8, "R2 record in first free slot", wn, 8);
        check_record(100 + s, s, 0);
      end else begin
        chk(wn == 0, "R3 no write when all used", wn, 0);
      end
    end
    chk(overrun, "R8 overrun sticky", int'(overrun), 1);
    chk(!mem_rd_valid && !mem_wr_valid && !busy, "R11 quiet when idle", int'(busy), 0);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule